// File: doc/BRIEF.md
# Write Commit Clock-Count Qualifier

This block sits next to the serial front-end of a three-wire serial memory and decides whether a write-type instruction may go on to programming. From the start bit until the chip select drops, it counts the serial clock rising edges, which reach it as single-cycle strobes in the system clock domain. It also captures the address and up to a page of data words. When the select falls, it compares the count with the exact length that the decoded instruction class needs. It also checks that the write-enable input stayed high for the whole time.

A matching instruction produces a one-cycle commit pulse. With the pulse come the start address, the word count, the captured words and the list of page word addresses, which wrap inside their low address field. Any mismatch produces a one-cycle abort pulse instead. The class of the instruction comes from an external decoder and must be valid in the cycle the select is seen low.

Top module: `write_commit_qualifier`

## Requirements
- R1: Counting begins at the first `sdi_i`=1 sampled on a `sck_rise_i` strobe while `sel_i` is high, and that edge counts as 1. Leading zeros and strobes while `sel_i` is low are not counted. Only the classes on `kind_i` (0 none, 1 single write, 2 page write, 3 fill-all, 4 protect set, 5 protect clear) that are write-type (1 to 5) produce a commit or an abort. Class 0, or a select with no start bit, produces neither.
- R2: A single write commits only with exactly 3+ADDR_W+DATA_W edges (27 by default). One more or one fewer aborts.
- R3: A fill-all needs 3+ADDR_W+DATA_W edges (27). Protect set and protect clear need 3+ADDR_W edges (11). Any other count aborts.
- R4: A page write commits only with 3+ADDR_W+DATA_W·N edges for N from 1 to PAGE_WORDS (11+16N by default), and reports N. A partial word or N>PAGE_WORDS aborts.
- R5: For a page commit, entry k of `page_addr_o` keeps the upper address bits of the start address and has low field (start low field + k) mod PAGE_WORDS. Entry 0 equals `addr_o`.
- R6: `wen_i` must be high in every cycle from the start bit through the cycle in which `sel_i` is first seen low. Otherwise the instruction aborts.
- R7: The edge counter saturates, so a burst of 2^CNT_W extra edges (128 by default) on a single write aborts and does not alias to a valid count.
- R8: A verdict appears as a one-cycle pulse in the cycle after the first clock edge that samples `sel_i` low. Commit and abort are never high together. On commit, `addr_o` holds the address bits (MSB first after the 3 header bits), `nwords_o` holds the count (1 for single write and fill-all, 0 for protect), and `data_o[k]` holds data word k, MSB first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_i | input | 1 | Chip select, synchronized |
| sck_rise_i | input | 1 | One-cycle strobe per serial clock rising edge |
| sdi_i | input | 1 | Serial data bit valid with the strobe |
| wen_i | input | 1 | Write-enable pin, synchronized |
| kind_i | input | 3 | Instruction class from the decoder |
| commit_o | output | 1 | One-cycle commit pulse |
| abort_o | output | 1 | One-cycle abort pulse |
| kind_o | output | 3 | Class of the committed instruction |
| addr_o | output | ADDR_W | Captured start address |
| nwords_o | output | clog2(PAGE_WORDS+1) | Number of data words committed |
| data_o | output | PAGE_WORDS×DATA_W | Captured data words |
| page_addr_o | output | PAGE_WORDS×ADDR_W | Word address for each page slot |

## Verification
The bench builds the block with its defaults: an 8-bit address, 16-bit words and a 4-word page. With these values the 27-, 11- and 11+16N-edge rules apply, and the counter is 7 bits wide. A 155-edge burst would therefore wrap onto the single-write length if the counter did not saturate. A start address whose low field is 2 makes a four-word page cross the wrap point. Five-word and partial-word pages probe the page bound.

// File: rtl/wcq_pkg.sv
package wcq_pkg;

    typedef enum logic [2:0] {
        KIND_NONE     = 3'd0,
        KIND_WRITE    = 3'd1,
        KIND_PAGE     = 3'd2,
        KIND_FILL     = 3'd3,
        KIND_PROT_SET = 3'd4,
        KIND_PROT_CLR = 3'd5
    } kind_e;

    // start bit plus two opcode bits
    localparam int unsigned HDR_BITS = 3;

    typedef struct packed {
        logic commit;
        logic abort;
    } verdict_t;

    function automatic logic is_write_type(kind_e k);
        return (k == KIND_WRITE) || (k == KIND_PAGE) || (k == KIND_FILL) ||
               (k == KIND_PROT_SET) || (k == KIND_PROT_CLR);
    endfunction

    // Exact edge count that a class needs; 0 means no legal length.
    function automatic int unsigned need_len(kind_e k, int unsigned aw,
                                             int unsigned dw, int unsigned words,
                                             int unsigned max_words);
        case (k)
            KIND_WRITE, KIND_FILL:       return HDR_BITS + aw + dw;
            KIND_PROT_SET, KIND_PROT_CLR: return HDR_BITS + aw;
            KIND_PAGE: begin
                if (words == 0 || words > max_words) return 0;
                return HDR_BITS + aw + dw * words;
            end
            default:                     return 0;
        endcase
    endfunction

endpackage

// File: rtl/wcq_edge_count.sv
module wcq_edge_count
    import wcq_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int CNT_W  = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sel_i,
    input  logic             sck_rise_i,
    input  logic             sdi_i,
    input  logic             wen_i,
    output logic             active_o,
    output logic [CNT_W-1:0] cnt_o,
    output logic             fall_o,
    output logic             w_ok_o,
    output logic             addr_shift_o,
    output logic             data_shift_o
);

    localparam logic [CNT_W-1:0] CNT_MAX   = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] ADDR_FROM = CNT_W'(HDR_BITS);
    localparam logic [CNT_W-1:0] DATA_FROM = CNT_W'(HDR_BITS + ADDR_W);

    logic sel_q;
    logic active_q;
    logic [CNT_W-1:0] cnt_q;
    logic w_ok_q;
    logic edge_live;
    logic start_now;

    assign edge_live = sel_i && sck_rise_i;
    assign start_now = edge_live && !active_q && sdi_i;

    always_ff @(posedge clk) begin
        if (rst) sel_q <= 1'b0;
        else     sel_q <= sel_i;
    end

    // R1: count from the start bit; R7: saturate at the top value
    always_ff @(posedge clk) begin
        if (rst || !sel_i) begin
            active_q <= 1'b0;
            cnt_q    <= '0;
        end else if (edge_live) begin
            if (!active_q) begin
                if (sdi_i) begin
                    active_q <= 1'b1;
                    cnt_q    <= CNT_W'(1);
                end
            end else if (cnt_q != CNT_MAX) begin
                cnt_q <= cnt_q + CNT_W'(1);
            end
        end
    end

    // R6: any low cycle of the enable from the start bit on spoils the instruction
    always_ff @(posedge clk) begin
        if (rst || !sel_i) begin
            w_ok_q <= 1'b1;
        end else if ((active_q || start_now) && !wen_i) begin
            w_ok_q <= 1'b0;
        end
    end

    assign active_o     = active_q;
    assign cnt_o        = cnt_q;
    assign fall_o       = sel_q && !sel_i;
    assign w_ok_o       = w_ok_q;
    assign addr_shift_o = edge_live && active_q && (cnt_q >= ADDR_FROM) && (cnt_q < DATA_FROM);
    assign data_shift_o = edge_live && active_q && (cnt_q >= DATA_FROM);

endmodule

// File: rtl/wcq_capture.sv
module wcq_capture #(
    parameter int ADDR_W     = 8,
    parameter int DATA_W     = 16,
    parameter int PAGE_WORDS = 4,
    parameter int WIDX_W     = 3
) (
    input  logic                                 clk,
    input  logic                                 rst,
    input  logic                                 sel_i,
    input  logic                                 sdi_i,
    input  logic                                 addr_shift_i,
    input  logic                                 data_shift_i,
    output logic [ADDR_W-1:0]                    addr_o,
    output logic [PAGE_WORDS-1:0][DATA_W-1:0]    words_o,
    output logic [WIDX_W-1:0]                    widx_o,
    output logic                                 word_edge_o
);

    localparam int DBIT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [DBIT_W-1:0] DBIT_LAST = DBIT_W'(DATA_W - 1);
    localparam logic [WIDX_W-1:0] WIDX_FULL = WIDX_W'(PAGE_WORDS);

    logic [ADDR_W-1:0]               addr_q;
    logic [PAGE_WORDS-1:0][DATA_W-1:0] words_q;
    logic [WIDX_W-1:0]               widx_q;
    logic [DBIT_W-1:0]               dbit_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
        end else if (addr_shift_i) begin
            addr_q <= {addr_q[ADDR_W-2:0], sdi_i};
        end
    end

    // Word and bit position within the data phase
    always_ff @(posedge clk) begin
        if (rst || !sel_i) begin
            widx_q <= '0;
            dbit_q <= '0;
        end else if (data_shift_i) begin
            if (dbit_q == DBIT_LAST) begin
                dbit_q <= '0;
                if (widx_q != WIDX_FULL) widx_q <= widx_q + WIDX_W'(1);
            end else begin
                dbit_q <= dbit_q + DBIT_W'(1);
            end
        end
    end

    genvar gw;
    generate
        for (gw = 0; gw < PAGE_WORDS; gw++) begin : g_word
            always_ff @(posedge clk) begin
                if (rst) begin
                    words_q[gw] <= '0;
                end else if (data_shift_i && (widx_q == WIDX_W'(gw))) begin
                    words_q[gw] <= {words_q[gw][DATA_W-2:0], sdi_i};
                end
            end
        end
    endgenerate

    assign addr_o      = addr_q;
    assign words_o     = words_q;
    assign widx_o      = widx_q;
    assign word_edge_o = (dbit_q == '0);

endmodule

// File: rtl/wcq_judge.sv
module wcq_judge
    import wcq_pkg::*;
#(
    parameter int ADDR_W     = 8,
    parameter int DATA_W     = 16,
    parameter int PAGE_WORDS = 4,
    parameter int CNT_W      = 7,
    parameter int WIDX_W     = 3
) (
    input  logic              fall_i,
    input  logic              active_i,
    input  kind_e             kind_i,
    input  logic [CNT_W-1:0]  cnt_i,
    input  logic [WIDX_W-1:0] widx_i,
    input  logic              word_edge_i,
    input  logic              w_ok_i,
    input  logic              wen_i,
    output verdict_t          verdict_o,
    output logic [WIDX_W-1:0] nwords_o
);

    logic        evaluate;
    logic        len_ok;
    logic        pass;
    int unsigned need;

    always_comb begin
        case (kind_i)
            KIND_PAGE:             nwords_o = widx_i;
            KIND_WRITE, KIND_FILL: nwords_o = WIDX_W'(1);
            default:               nwords_o = '0;
        endcase
    end

    // R2, R3, R4: the count must equal the class length exactly
    always_comb begin
        need     = need_len(kind_i, ADDR_W, DATA_W, 32'(widx_i), PAGE_WORDS);
        evaluate = fall_i && active_i && is_write_type(kind_i);
        len_ok   = (need != 0) && (32'(cnt_i) == need) &&
                   ((kind_i != KIND_PAGE) || word_edge_i);
        pass     = len_ok && w_ok_i && wen_i;
        verdict_o.commit = evaluate && pass;
        verdict_o.abort  = evaluate && !pass;
    end

endmodule

// File: rtl/write_commit_qualifier.sv
module write_commit_qualifier
    import wcq_pkg::*;
#(
    parameter int ADDR_W     = 8,
    parameter int DATA_W     = 16,
    parameter int PAGE_WORDS = 4
) (
    input  logic                                       clk,
    input  logic                                       rst,
    input  logic                                       sel_i,
    input  logic                                       sck_rise_i,
    input  logic                                       sdi_i,
    input  logic                                       wen_i,
    input  logic [2:0]                                 kind_i,
    output logic                                       commit_o,
    output logic                                       abort_o,
    output logic [2:0]                                 kind_o,
    output logic [ADDR_W-1:0]                          addr_o,
    output logic [$clog2(PAGE_WORDS+1)-1:0]            nwords_o,
    output logic [PAGE_WORDS-1:0][DATA_W-1:0]          data_o,
    output logic [PAGE_WORDS-1:0][ADDR_W-1:0]          page_addr_o
);

    localparam int MAX_LEN = HDR_BITS + ADDR_W + DATA_W * PAGE_WORDS;
    localparam int CNT_W   = $clog2(MAX_LEN + 2);
    localparam int WIDX_W  = $clog2(PAGE_WORDS + 1);
    localparam int LW      = $clog2(PAGE_WORDS);

    kind_e                           kind_w;
    logic                            active_w;
    logic [CNT_W-1:0]                cnt_w;
    logic                            fall_w;
    logic                            w_ok_w;
    logic                            addr_shift_w;
    logic                            data_shift_w;
    logic [ADDR_W-1:0]               cap_addr_w;
    logic [PAGE_WORDS-1:0][DATA_W-1:0] cap_words_w;
    logic [WIDX_W-1:0]               widx_w;
    logic                            word_edge_w;
    verdict_t                        verdict_w;
    logic [WIDX_W-1:0]               nwords_w;

    assign kind_w = kind_e'(kind_i);

    wcq_edge_count #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_count (
        .clk          (clk),
        .rst          (rst),
        .sel_i        (sel_i),
        .sck_rise_i   (sck_rise_i),
        .sdi_i        (sdi_i),
        .wen_i        (wen_i),
        .active_o     (active_w),
        .cnt_o        (cnt_w),
        .fall_o       (fall_w),
        .w_ok_o       (w_ok_w),
        .addr_shift_o (addr_shift_w),
        .data_shift_o (data_shift_w)
    );

    wcq_capture #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_WORDS(PAGE_WORDS),
                  .WIDX_W(WIDX_W)) u_capture (
        .clk          (clk),
        .rst          (rst),
        .sel_i        (sel_i),
        .sdi_i        (sdi_i),
        .addr_shift_i (addr_shift_w),
        .data_shift_i (data_shift_w),
        .addr_o       (cap_addr_w),
        .words_o      (cap_words_w),
        .widx_o       (widx_w),
        .word_edge_o  (word_edge_w)
    );

    wcq_judge #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_WORDS(PAGE_WORDS),
                .CNT_W(CNT_W), .WIDX_W(WIDX_W)) u_judge (
        .fall_i      (fall_w),
        .active_i    (active_w),
        .kind_i      (kind_w),
        .cnt_i       (cnt_w),
        .widx_i      (widx_w),
        .word_edge_i (word_edge_w),
        .w_ok_i      (w_ok_w),
        .wen_i       (wen_i),
        .verdict_o   (verdict_w),
        .nwords_o    (nwords_w)
    );

    // R8: registered verdict pulses
    always_ff @(posedge clk) begin
        if (rst) begin
            commit_o <= 1'b0;
            abort_o  <= 1'b0;
        end else begin
            commit_o <= verdict_w.commit;
            abort_o  <= verdict_w.abort;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            kind_o   <= '0;
            addr_o   <= '0;
            nwords_o <= '0;
            data_o   <= '0;
        end else if (verdict_w.commit) begin
            kind_o   <= kind_i;
            addr_o   <= cap_addr_w;
            nwords_o <= nwords_w;
            data_o   <= cap_words_w;
        end
    end

    // R5: slot addresses advance only in the low field
    genvar gk;
    generate
        for (gk = 0; gk < PAGE_WORDS; gk++) begin : g_slot
            always_ff @(posedge clk) begin
                if (rst) begin
                    page_addr_o[gk] <= '0;
                end else if (verdict_w.commit) begin
                    page_addr_o[gk] <= {cap_addr_w[ADDR_W-1:LW],
                                        cap_addr_w[LW-1:0] + LW'(gk)};
                end
            end
        end
    endgenerate

endmodule

// File: rtl/wcq_checker.sv
module wcq_checker
    import wcq_pkg::*;
#(
    parameter int ADDR_W     = 8,
    parameter int DATA_W     = 16,
    parameter int PAGE_WORDS = 4
) (
    input logic                                    clk,
    input logic                                    rst,
    input logic                                    sel_i,
    input logic                                    wen_i,
    input logic [2:0]                              kind_i,
    input logic                                    commit_o,
    input logic                                    abort_o,
    input logic [2:0]                              kind_o,
    input logic [ADDR_W-1:0]                       addr_o,
    input logic [$clog2(PAGE_WORDS+1)-1:0]         nwords_o,
    input logic [PAGE_WORDS-1:0][ADDR_W-1:0]       page_addr_o
);

    localparam int LW = $clog2(PAGE_WORDS);

    p_exclusive_r8: assert property (@(posedge clk) disable iff (rst)
        !(commit_o && abort_o));

    p_single_pulse_r8: assert property (@(posedge clk) disable iff (rst)
        commit_o |=> !commit_o);

    p_after_deselect_r8: assert property (@(posedge clk) disable iff (rst)
        (commit_o || abort_o) |-> !$past(sel_i));

    p_enable_held_r6: assert property (@(posedge clk) disable iff (rst)
        commit_o |-> $past(wen_i));

    p_write_class_r1: assert property (@(posedge clk) disable iff (rst)
        (commit_o || abort_o) |-> ($past(kind_i) != 3'd0));

    p_page_count_r4: assert property (@(posedge clk) disable iff (rst)
        (commit_o && kind_o == 3'(KIND_PAGE)) |->
            (nwords_o != '0) && (32'(nwords_o) <= PAGE_WORDS));

    p_slot0_r5: assert property (@(posedge clk) disable iff (rst)
        commit_o |-> page_addr_o[0] == addr_o);

    genvar gk;
    generate
        for (gk = 1; gk < PAGE_WORDS; gk++) begin : g_wrap
            p_wrap_r5: assert property (@(posedge clk) disable iff (rst)
                commit_o |->
                    (page_addr_o[gk][LW-1:0] == page_addr_o[gk-1][LW-1:0] + LW'(1)) &&
                    (page_addr_o[gk][ADDR_W-1:LW] == addr_o[ADDR_W-1:LW]));
        end
    endgenerate

endmodule

bind write_commit_qualifier wcq_checker #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_WORDS(PAGE_WORDS)
) u_wcq_checker (
    .clk         (clk),
    .rst         (rst),
    .sel_i       (sel_i),
    .wen_i       (wen_i),
    .kind_i      (kind_i),
    .commit_o    (commit_o),
    .abort_o     (abort_o),
    .kind_o      (kind_o),
    .addr_o      (addr_o),
    .nwords_o    (nwords_o),
    .page_addr_o (page_addr_o)
);

// File: tb/tb_write_commit_qualifier.sv
`timescale 1ns/1ps
module tb_write_commit_qualifier;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sel_i = 1'b0;
    logic sck_rise_i = 1'b0;
    logic sdi_i = 1'b0;
    logic wen_i = 1'b1;
    logic [2:0] kind_i = 3'd0;
    logic commit_o;
    logic abort_o;
    logic [2:0] kind_o;
    logic [7:0] addr_o;
    logic [2:0] nwords_o;
    logic [3:0][15:0] data_o;
    logic [3:0][7:0] page_addr_o;

    write_commit_qualifier dut (
        .clk(clk), .rst(rst), .sel_i(sel_i), .sck_rise_i(sck_rise_i),
        .sdi_i(sdi_i), .wen_i(wen_i), .kind_i(kind_i),
        .commit_o(commit_o), .abort_o(abort_o), .kind_o(kind_o),
        .addr_o(addr_o), .nwords_o(nwords_o), .data_o(data_o),
        .page_addr_o(page_addr_o)
    );

    always #2.5 clk = ~clk;

    int n_cmp = 0;
    int n_bad = 0;
    bit running = 0;
    bit done = 0;

    // expected state for the next compare
    bit exp_c = 0;
    bit exp_a = 0;
    int exp_kind = 0;
    int exp_addr = 0;
    int exp_n = 0;
    int exp_words [0:3];
    string exp_tag = "R8";

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // Reference compare on every clock, 1 ns after the edge
    always @(posedge clk) begin
        #1;
        if (running && !rst) begin
            check(commit_o == exp_c, exp_tag, "commit", int'(commit_o), int'(exp_c));
            check(abort_o == exp_a, exp_tag, "abort", int'(abort_o), int'(exp_a));
            if (exp_c && commit_o) begin
                check(int'(kind_o) == exp_kind, "R8", "kind", int'(kind_o), exp_kind);
                check(int'(addr_o) == exp_addr, "R8", "addr", int'(addr_o), exp_addr);
                check(int'(nwords_o) == exp_n, exp_tag, "nwords", int'(nwords_o), exp_n);
                for (int j = 0; j < exp_n && j < 4; j++) begin
                    check(int'(data_o[j]) == exp_words[j], "R8", "data word",
                          int'(data_o[j]), exp_words[j]);
                end
                if (exp_kind == 2) begin
                    for (int j = 0; j < 4; j++) begin
                        int pa;
                        pa = (exp_addr & 8'hFC) | ((exp_addr + j) & 3);
                        check(int'(page_addr_o[j]) == pa, "R5", "page addr",
                              int'(page_addr_o[j]), pa);
                    end
                end
            end
            exp_c = 0;
            exp_a = 0;
        end
    end

    task automatic send_bit(input logic b, input bit wl);
        @(negedge clk);
        sck_rise_i = 1'b1;
        sdi_i = b;
        wen_i = !wl;
        @(negedge clk);
        sck_rise_i = 1'b0;
        wen_i = 1'b1;
    endtask

    // One select window. extra > 0 appends bits, extra < 0 drops bits.
    // wlow: edge number with W low (0 none, edges+1 means low at deselect).
    task automatic xfer(input int k, input int a, input int nw, input int extra,
                        input int wlow, input int lead0, input int noise,
                        input string tag);
        logic q[$];
        int e;
        int wd [0:7];
        bit wt, len_ok;
        for (int j = 0; j < 8; j++) wd[j] = ((j + 1) * 16'h1357 ^ (a << 4) ^ 16'hA50F) & 16'hFFFF;
        q.push_back(1'b1);
        q.push_back(1'b0);
        q.push_back(1'b1);
        for (int i = 7; i >= 0; i--) q.push_back(a[i]);
        for (int j = 0; j < nw; j++)
            for (int i = 15; i >= 0; i--) q.push_back(wd[j][i]);
        for (int i = 0; i < extra; i++) q.push_back(logic'(i % 2));
        for (int i = 0; i < -extra; i++) void'(q.pop_back());
        e = q.size();

        // strobes while deselected must not count (R1)
        for (int i = 0; i < noise; i++) send_bit(1'b1, 1'b0);
        @(negedge clk);
        sel_i = 1'b1;
        kind_i = 3'(k);
        for (int i = 0; i < lead0; i++) send_bit(1'b0, 1'b0);
        for (int i = 0; i < e; i++) send_bit(q[i], (wlow == i + 1));

        // independent expectation from the requirements
        wt = (k >= 1 && k <= 5);
        case (k)
            1, 3: len_ok = (e == 27);
            4, 5: len_ok = (e == 11);
            2:    len_ok = (e > 11) && ((e - 11) % 16 == 0) && ((e - 11) / 16 <= 4);
            default: len_ok = 0;
        endcase
        if (wlow >= 1 && wlow <= e + 1) len_ok = 0;
        exp_tag = tag;
        exp_c = wt && len_ok;
        exp_a = wt && !len_ok;
        exp_kind = k;
        exp_addr = a;
        exp_n = (k == 2) ? (e - 11) / 16 : ((k == 1 || k == 3) ? 1 : 0);
        for (int j = 0; j < 4; j++) exp_words[j] = wd[j];
        if (wlow == e + 1) wen_i = 1'b0;
        sel_i = 1'b0;
        @(negedge clk);
        wen_i = 1'b1;
        kind_i = 3'd0;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(commit_o == 1'b0 && abort_o == 1'b0, "R8", "reset state",
              int'({commit_o, abort_o}), 0);
        running = 1;

        xfer(1, 8'h5A, 1, 0, 0, 0, 0, "R2");     // exact single write
        xfer(1, 8'h33, 1, 1, 0, 0, 0, "R2");     // 28 edges
        xfer(1, 8'h33, 1, -1, 0, 0, 0, "R2");    // 26 edges
        xfer(3, 8'hC0, 1, 0, 0, 0, 0, "R3");     // fill-all 27
        xfer(4, 8'h7E, 0, 0, 0, 0, 0, "R3");     // protect set 11
        xfer(5, 8'hFF, 0, 0, 0, 0, 0, "R3");     // protect clear 11
        xfer(4, 8'h7E, 0, 1, 0, 0, 0, "R3");     // protect set 12
        xfer(3, 8'hC0, 1, -2, 0, 0, 0, "R3");    // fill-all 25
        for (int n = 1; n <= 4; n++)
            xfer(2, 8'h4E, n, 0, 0, 0, 0, "R4"); // wraps 4E,4F,4C,4D
        xfer(2, 8'h91, 4, 0, 0, 0, 0, "R5");
        xfer(2, 8'h10, 1, 5, 0, 0, 0, "R4");     // partial word
        xfer(2, 8'h10, 5, 0, 0, 0, 0, "R4");     // five words
        xfer(1, 8'h22, 1, 0, 15, 0, 0, "R6");    // W low mid-stream
        xfer(1, 8'h22, 1, 0, 28, 0, 0, "R6");    // W low at deselect
        xfer(1, 8'h22, 1, 0, 1, 0, 0, "R6");     // W low on start bit
        xfer(1, 8'h66, 1, 128, 0, 0, 0, "R7");   // 155 edges
        xfer(0, 8'h66, 1, 0, 0, 0, 0, "R1");     // class none
        xfer(1, 8'hA5, 1, 0, 0, 5, 3, "R1");     // leading zeros and noise
        xfer(2, 8'h03, 2, 0, 0, 2, 2, "R1");
        xfer(1, 8'h0F, 1, 0, 0, 0, 0, "R8");

        running = 0;
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL R8 watchdog: actual hung expected finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule